// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Timing Generator

This block produces eight non-overlapping timing phases from a four-stage twisted-ring (switch-tail) counter. Four flip-flops, named X, Y, Z and T from the head of the ring to its tail, shift one place per enabled clock. The inverse of the tail bit feeds the head. The register therefore walks through eight states, each a run of ones entering or leaving the ring. Every state has its own timing output, and each output is the AND of just two adjacent register bits (true or inverted).

A plain ring wiring leaves the eight remaining four-bit patterns in a second loop that never meets the useful one. Here the head-to-second-stage path is gated, so that every one of those stray patterns drains back to the all-zero state. From there the counter resumes the normal cycle. A synchronous preset lets a controller (or a bench) place any pattern in the register. This is the only way to exercise the recovery path from the ports.

Top module: `johnson_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 0000 on that edge, overriding `preset_en` and `en`. After reset `tick` reads 8'b0000_0001.
- R2: With `rst`, `preset_en` and `en` all low at an edge, `cnt_q` keeps its value.
- R3: `cnt_q[3]`=X, `cnt_q[2]`=Y, `cnt_q[1]`=Z and `cnt_q[0]`=T. Each enabled edge steps a valid state to the next one in this cycle: 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, then back to 0000 (written XYZT).
- R4: `tick` is decoded from the current register value with no extra delay. `tick[0]`=X'T', `tick[1]`=XY', `tick[2]`=YZ', `tick[3]`=ZT', `tick[4]`=XT, `tick[5]`=X'Y, `tick[6]`=Y'Z and `tick[7]`=Z'T. In the k-th state of the R3 cycle (counting from 0), only `tick[k]` is high.
- R5: With `rst` low and `preset_en` high at an edge, `cnt_q` takes `preset_val`, whatever the value of `en`.
- R6: From any unused pattern, enabled edges follow the chain 0100, 1010, 1101, 0110, 1011, 0101, 0010, 1001, 0000. Every unused pattern therefore reaches 0000 within 8 enabled edges, and 0000 is the first valid state it enters.
- R7: Once in a valid state, enabled or held operation without preset never leaves the R3 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0000 |
| en | input | 1 | Advance the register by one step |
| preset_en | input | 1 | Load `preset_val` on this edge |
| preset_val | input | 4 | Pattern to load, XYZT order |
| cnt_q | output | 4 | Register bits X,Y,Z,T (bit 3 = X) |
| tick | output | 8 | Decoded timing phases S0..S7 |

## Verification
The assertions take for granted that `rst`, `en`, `preset_en` and `preset_val` are stable around each rising edge and never unknown once reset has been applied. The bench changes them only on the falling edge and sets all of them to known values at time zero. The hold and stay-in-cycle properties assume that no preset is pending. The stimulus keeps preset rare and applies it only through a task that drives all inputs together. The recovery property assumes that unused patterns arrive only by preset, because that is the only way the bench creates them.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int JC_BITS  = 4;
  localparam int JC_TICKS = 2 * JC_BITS;
  localparam int BIT_X = JC_BITS - 1;
  localparam int BIT_Y = JC_BITS - 2;
  localparam int BIT_Z = JC_BITS - 3;
  localparam int BIT_T = 0;

  typedef logic [JC_BITS-1:0]  jc_state_t;
  typedef logic [JC_TICKS-1:0] jc_tick_t;
endpackage

// File: rtl/jc_next.sv
module jc_next
  import jc_pkg::*;
(
  input  jc_state_t cur,
  output jc_state_t nxt
);
  // head takes the inverted tail (twist)
  assign nxt[BIT_X] = ~cur[BIT_T];
  // second stage is gated so stray patterns drain toward 0000
  assign nxt[BIT_Y] = cur[BIT_X] & (cur[BIT_Y] | cur[BIT_Z] | ~cur[BIT_T]);

  // remaining stages are a plain shift
  genvar g;
  generate
    for (g = 0; g < JC_BITS - 2; g++) begin : g_shift
      assign nxt[g] = cur[g+1];
    end
  endgenerate
endmodule

// File: rtl/jc_decode.sv
module jc_decode
  import jc_pkg::*;
(
  input  jc_state_t st,
  output jc_tick_t  phase
);
  // phase k and k+JC_BITS share one adjacent bit pair (lead, trail)
  genvar k;
  generate
    for (k = 0; k < JC_BITS; k++) begin : g_pair
      logic lead;
      logic trail;
      if (k == 0) begin : g_wrap
        assign lead = ~st[BIT_T];
      end else begin : g_mid
        assign lead = st[JC_BITS-k];
      end
      assign trail = st[JC_BITS-1-k];
      assign phase[k]         = lead & ~trail;
      assign phase[k+JC_BITS] = ~lead & trail;
    end
  endgenerate
endmodule

// File: rtl/johnson_timer.sv
module johnson_timer
  import jc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                preset_en,
  input  logic [JC_BITS-1:0]  preset_val,
  output logic [JC_BITS-1:0]  cnt_q,
  output logic [JC_TICKS-1:0] tick
);
  jc_state_t step_d;

  jc_next u_next (
    .cur (cnt_q),
    .nxt (step_d)
  );

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (preset_en) cnt_q <= preset_val;
    else if (en)        cnt_q <= step_d;
  end

  jc_decode u_dec (
    .st    (cnt_q),
    .phase (tick)
  );

  // membership in the useful cycle, used only by the properties below
  logic seq_ok;
  assign seq_ok = (cnt_q == 4'b0000) || (cnt_q == 4'b1000) ||
                  (cnt_q == 4'b1100) || (cnt_q == 4'b1110) ||
                  (cnt_q == 4'b1111) || (cnt_q == 4'b0111) ||
                  (cnt_q == 4'b0011) || (cnt_q == 4'b0001);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && !preset_en) |=> $stable(cnt_q));

  p_one_phase_r4: assert property (@(posedge clk) disable iff (rst)
    seq_ok |-> ($countones(tick) == 1));

  p_preset_load_r5: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> (cnt_q == $past(preset_val)));

  p_enter_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!seq_ok && en && !preset_en) |=> (!seq_ok || cnt_q == '0));

  p_stay_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_ok && !preset_en) |=> seq_ok);

  p_one_bit_step_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_ok && en && !preset_en) |=>
      (($countones(cnt_q) == $countones($past(cnt_q)) + 1) ||
       ($countones(cnt_q) + 1 == $countones($past(cnt_q)))));
endmodule

// File: tb/johnson_timer_test.sv
module johnson_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       preset_en = 1'b0;
  logic [3:0] preset_val = 4'b0000;
  logic [3:0] cnt_q;
  logic [7:0] tick;

  int checks_n = 0;
  int fails_n  = 0;
  bit done     = 1'b0;
  logic [3:0] model = 4'b0000;

  localparam logic [3:0] VSEQ  [8] = '{4'b0000, 4'b1000, 4'b1100, 4'b1110,
                                       4'b1111, 4'b0111, 4'b0011, 4'b0001};
  localparam logic [3:0] CHAIN [9] = '{4'b0100, 4'b1010, 4'b1101, 4'b0110,
                                       4'b1011, 4'b0101, 4'b0010, 4'b1001,
                                       4'b0000};

  johnson_timer uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .preset_en  (preset_en),
    .preset_val (preset_val),
    .cnt_q      (cnt_q),
    .tick       (tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int seq_idx(input logic [3:0] s);
    for (int i = 0; i < 8; i++) if (VSEQ[i] == s) return i;
    return -1;
  endfunction

  function automatic logic [3:0] succ(input logic [3:0] s);
    int k;
    k = seq_idx(s);
    if (k >= 0) return VSEQ[(k+1) % 8];
    for (int i = 0; i < 8; i++) if (CHAIN[i] == s) return CHAIN[i+1];
    return 4'bxxxx;
  endfunction

  task automatic expect_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks_n++;
    if (act !== exp) begin
      fails_n++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int k;
    expect_eq(req, {4'b0, cnt_q}, {4'b0, model});
    k = seq_idx(model);
    if (k >= 0) expect_eq({req, "/R4"}, tick, 8'b1 << k);
  endtask

  task automatic cycle(input logic r, input logic e, input logic p,
                       input logic [3:0] pv, input string req);
    @(negedge clk);
    rst = r; en = e; preset_en = p; preset_val = pv;
    @(posedge clk);
    #1;
    if (r)      model = 4'b0000;
    else if (p) model = pv;
    else if (e) model = succ(model);
    compare(req);
  endtask

  initial begin
    int steps;
    void'($urandom(32'd4242));
    // R1: reset, also over preset and enable
    cycle(1'b1, 1'b1, 1'b1, 4'b1010, "R1");
    expect_eq("R1 tick", tick, 8'b0000_0001);
    // R3: two laps of the cycle
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, 1'b0, 4'b0000, "R3");
    // R2: hold mid-cycle
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b0, 4'b0000, "R3");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, 4'b0110, "R2");
    // R5: preset with enable low and high
    cycle(1'b0, 1'b0, 1'b1, 4'b1110, "R5");
    cycle(1'b0, 1'b1, 1'b1, 4'b0011, "R5");
    // R6 / R7: every unused pattern drains to 0000 then cycles normally
    for (int u = 0; u < 8; u++) begin
      cycle(1'b0, 1'b0, 1'b1, CHAIN[u], "R5");
      steps = 0;
      while (seq_idx(cnt_q) < 0 && steps < 10) begin
        cycle(1'b0, 1'b1, 1'b0, 4'b0000, "R6");
        steps++;
      end
      expect_eq("R6 steps<=8", {7'b0, steps <= 8}, 8'd1);
      expect_eq("R6 entry", {4'b0, cnt_q}, 8'h00);
      for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, 1'b0, 4'b0000, "R7");
    end
    // R2: hold on an unused pattern
    cycle(1'b0, 1'b0, 1'b1, 4'b1101, "R5");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, 4'b0000, "R2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, e, p;
      logic [3:0] v;
      r = ($urandom % 40) == 0;
      p = ($urandom % 25) == 0;
      e = ($urandom % 4) != 0;
      v = 4'($urandom);
      cycle(r, e, p, v, "R3 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks_n, fails_n);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks_n++;
      fails_n++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks_n, fails_n);
      $finish;
    end
  end
endmodule